// File: doc/BRIEF.md
# Graphics Interrupt Control Register

This block is the interrupt control and status word of a graphics engine. It tracks three interrupt sources: error, vertical blank and packet-buffer done. Each source sits in its own 4-bit field, and the three fields are spaced one byte apart in a 32-bit register. Each field holds an enable bit and a request flag. The engine drives one single-cycle event pulse per source. A pulse latches that source's request flag. The host reads the word, and it writes the word to enable sources or to acknowledge them.

A host write changes only the fields whose gate bit is set in the written data. Software can therefore acknowledge one source without disturbing the state of the others, and no read-modify-write is needed. The block drives a single level-sensitive interrupt line. The line stays high while any source is both enabled and requesting.

Top module: `gfx_irq_ctrl`

## Requirements
- R1: After reset every enable and request bit is 0, the read word is 0 and the interrupt output is low.
- R2: The fields sit at bit 0 (error), bit 8 (vertical blank) and bit 16 (packet done). Within a field, offset 0 is enable, offset 1 is request and offset 2 is the write gate.
- R3: A read returns the enable and request bits in place. Every other bit reads 0, including the field top bits and the bits above bit 18.
- R4: The write-gate bits are write-only and always read 0.
- R5: On a write, a field's enable and request bits take the written values only if that field's gate bit is set in the write data.
- R6: A field whose gate bit is clear in the write data keeps its enable and request bits.
- R7: A write with the gate set and the request bit 0 clears a pending request (acknowledge).
- R8: An event pulse sets its request bit one cycle later, whatever the enable state.
- R9: An event pulse in the same cycle as a clearing write to that field leaves the request set.
- R10: The interrupt output is high exactly when some field has both its enable bit and its request bit set. It follows the register contents with no extra delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_valid_i | input | 1 | Write strobe |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Current register read value |
| evt_i | input | 3 | Event pulses: [0] error, [1] vertical blank, [2] packet done |
| irq_o | output | 1 | Level interrupt to host |

## Verification
The hardest case to reach from the ports is an event pulse that lands in the same cycle as an acknowledge write to the same field. The bench drives the event and the write strobe from one task, on one falling edge. It then checks that the request survives.

The inverse case needs its own stimulus: a write with the gate clear arriving together with an event on another field. The bench drives that after several fields already hold state, so that each field's isolation is seen on the read word.

// File: rtl/gfx_irq_pkg.sv
package gfx_irq_pkg;
  localparam int unsigned NUM_SRC    = 3;
  localparam int unsigned DATA_W     = 32;
  localparam int unsigned FIELD_STEP = 8;
  localparam int unsigned EN_OFS     = 0;
  localparam int unsigned REQ_OFS    = 1;
  localparam int unsigned GATE_OFS   = 2;

  typedef struct packed {
    logic req;
    logic en;
  } irq_field_t;
endpackage

// File: rtl/gfx_irq_field.sv
module gfx_irq_field
  import gfx_irq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic       en_d_i,
  input  logic       req_d_i,
  input  logic       evt_i,
  output irq_field_t st_o,
  output logic       pend_o
);
  irq_field_t st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= '0;
    end else begin
      if (wr_i) st_q.en <= en_d_i;
      // event beats a clearing write
      if (evt_i)     st_q.req <= 1'b1;
      else if (wr_i) st_q.req <= req_d_i;
    end
  end

  assign st_o   = st_q;
  assign pend_o = st_q.en & st_q.req;

  // R8
  evt_sets_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i |=> st_q.req);
  // R6
  no_wr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && !evt_i) |=> $stable(st_q));
  // R7
  ack_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !req_d_i && !evt_i) |=> !st_q.req);
endmodule

// File: rtl/gfx_irq_ctrl.sv
module gfx_irq_ctrl
  import gfx_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic [NUM_SRC-1:0] evt_i,
  output logic              irq_o
);
  irq_field_t [NUM_SRC-1:0] st;
  logic [NUM_SRC-1:0] pend;
  logic [NUM_SRC-1:0] gate_wr;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    localparam int unsigned BASE = g * FIELD_STEP;
    assign gate_wr[g] = wr_valid_i & wr_data_i[BASE+GATE_OFS];
    gfx_irq_field u_field (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (gate_wr[g]),
      .en_d_i  (wr_data_i[BASE+EN_OFS]),
      .req_d_i (wr_data_i[BASE+REQ_OFS]),
      .evt_i   (evt_i[g]),
      .st_o    (st[g]),
      .pend_o  (pend[g])
    );
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      rd_data_o[i*FIELD_STEP+EN_OFS]  = st[i].en;
      rd_data_o[i*FIELD_STEP+REQ_OFS] = st[i].req;
    end
  end

  assign irq_o = |pend;

  // R4
  gate_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[GATE_OFS] == 1'b0 && rd_data_o[FIELD_STEP+GATE_OFS] == 1'b0
    && rd_data_o[2*FIELD_STEP+GATE_OFS] == 1'b0);
  // R10
  irq_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (|(rd_data_o[DATA_W-1:0] & (rd_data_o >> 1) & 32'h0001_0101)));
  // R3
  unused_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o & ~32'h0003_0303) == '0);
endmodule

// File: tb/gfx_irq_ctrl_test.sv
module gfx_irq_ctrl_test;
  logic        clk = 0;
  logic        rst_ni = 0;
  logic        wr_valid = 0;
  logic [31:0] wr_data = 0;
  logic [31:0] rd_data;
  logic [2:0]  evt = 0;
  logic        irq;
  int tests = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  gfx_irq_ctrl uut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_valid_i(wr_valid), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .evt_i(evt), .irq_o(irq));

  task automatic chk(string req, logic [31:0] exp_rd, logic exp_irq);
    tests++;
    if (rd_data !== exp_rd || irq !== exp_irq) begin
      fails++;
      $display("FAIL %s: rd=%h irq=%b expected rd=%h irq=%b", req, rd_data, irq, exp_rd, exp_irq);
    end
  endtask

  // drive on falling edge, return after next falling edge
  task automatic cyc(logic wv, logic [31:0] wd, logic [2:0] ev);
    @(negedge clk); wr_valid = wv; wr_data = wd; evt = ev;
    @(negedge clk); wr_valid = 0; wr_data = 0; evt = 0;
  endtask

  task automatic t_reset;
    chk("R1", 32'h0, 1'b0);
  endtask

  task automatic t_events_no_enable;
    cyc(0, 0, 3'b001); chk("R8 err", 32'h0000_0002, 0);
    cyc(0, 0, 3'b110); chk("R8 vb/pd", 32'h0002_0202, 0);
  endtask

  task automatic t_gate;
    // gate clear in all fields: nothing changes
    cyc(1, 32'h0003_0303, 0); chk("R6 no gate", 32'h0002_0202, 0);
    // enable vertical blank only, keep req
    cyc(1, 32'h0000_0700, 0); chk("R5 R10 vb enable", 32'h0002_0302, 1);
    // ack vertical blank, keep enable
    cyc(1, 32'h0000_0500, 0); chk("R7 vb ack", 32'h0002_0102, 0);
    // ack error and packet done together, set enable for pd
    cyc(1, 32'h0005_0004, 0); chk("R7 err/pd ack", 32'h0001_0100, 0);
  endtask

  task automatic t_all_bits;
    cyc(1, 32'hFFFF_FFFF, 0); chk("R3 R4 all ones", 32'h0003_0303, 1);
    cyc(1, 32'h0004_0404, 0); chk("R7 clear all", 32'h0, 0);
  endtask

  task automatic t_collision;
    cyc(1, 32'h0000_0005, 0); chk("R10 err en only", 32'h0000_0001, 0);
    cyc(0, 0, 3'b001); chk("R10 err irq", 32'h0000_0003, 1);
    cyc(1, 32'h0000_0005, 3'b001); chk("R9 event beats ack", 32'h0000_0003, 1);
    cyc(1, 32'h0000_0004, 3'b100); chk("R9 R2 ack err, pd event", 32'h0002_0000, 0);
    cyc(1, 32'h0001_0000, 3'b010); chk("R6 ungated write", 32'h0002_0200, 0);
  endtask

  task automatic t_reset_again;
    @(negedge clk); rst_ni = 0;
    @(negedge clk); chk("R1 async reset", 32'h0, 0);
    rst_ni = 1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1;
    t_events_no_enable();
    t_gate();
    t_all_bits();
    t_collision();
    t_reset_again();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (2000) @(posedge clk);
        fails++; tests++;
        $display("FAIL watchdog: expected completion");
      end
    join_any
    disable fork;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule